// File: doc/BRIEF.md
# Ray-Primitive Mailbox Filter

This block stands in front of a ray-primitive intersection unit while a ray walks a spatial grid or tree. A primitive that spans several cells is met again by the same ray, and only its first meeting needs an intersection test. The block keeps one mailbox entry for each primitive. The entry holds the number of the last ray tested against that primitive. Each request carries a primitive index and an opaque ray handle. The block stamps the request with its own ray number, which rises strictly. It then decides whether to pass the request on to the intersector or to skip it.

A one-cycle pulse on `new_ray_i` starts the next ray. Ray numbers run from 1 up to all-ones. Zero is kept to mean "never tested". When the number would wrap, every mailbox is cleared in the same edge and numbering restarts at 1. Requests are accepted one per cycle with no backpressure. Each decision comes out two cycles after its request.

Top module: `ray_mailbox_filter`

## Requirements
- R1: After reset no decision and no forward are signalled, the first ray number is 1 and every mailbox entry is empty (zero).
- R2: A pulse on `new_ray_i` raises the ray number by one for requests in later cycles. A request in the same cycle as the pulse is stamped with the previous number. `dec_num_o` reports the number that was used.
- R3: The first request for any primitive after reset passes.
- R4: A request passes only when its ray number is greater than the primitive's mailbox entry. A pass stores the ray number into that entry, and a skip leaves the entry unchanged.
- R5: The decision for a request appears on the outputs exactly two clock cycles after the request cycle, together with its primitive index and ray handle. `fwd_valid_o` is high only for a passing decision.
- R6: Of two requests in consecutive cycles for the same primitive, the second is judged against the value stored by the first.
- R7: A `new_ray_i` pulse while the ray number is all-ones (2^RAY_W-1) sets the next number to 1 and clears every mailbox entry in the same edge. The clear overrides any store that lands on that edge.
- R8: A request made in the wrap cycle is judged with the old number against the old contents, and it stores nothing, so its primitive passes again under ray number 1.
- R9: Mailbox entries of different primitives are independent.
- R10: A new ray passes primitives that earlier rays have already tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_ray_i | input | 1 | One-cycle pulse that advances to the next ray |
| req_valid_i | input | 1 | Request present this cycle |
| req_prim_i | input | PRIM_W | Primitive index of the request |
| req_ray_i | input | RID_W | Opaque ray handle carried to the intersector |
| dec_valid_o | output | 1 | A decision is presented |
| dec_pass_o | output | 1 | Decision is pass (test needed) |
| dec_prim_o | output | PRIM_W | Primitive index of the decision |
| dec_ray_o | output | RID_W | Ray handle of the decision |
| dec_num_o | output | RAY_W | Ray number the decision used |
| fwd_valid_o | output | 1 | Request forwarded to the intersector |

## Verification
The hardest situation to reach is the wrap edge. It needs the ray number at all-ones, a store from the previous cycle landing on the very edge of the clear, and a request issued in the wrap cycle itself. The stimulus resets the block, drives fourteen idle ray pulses to bring the number to its maximum, and then issues requests in the cycles just before, during and after the wrap pulse. It then checks that the entries touched on either side of the clear pass again under number 1. The read-after-write path is reached by back-to-back requests for one primitive both in the vector table and around the wrap.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    VERD_IDLE = 2'd0,
    VERD_SKIP = 2'd1,
    VERD_PASS = 2'd2
  } verdict_e;

  // a ray number beats a stored entry only when strictly larger
  function automatic logic ray_is_newer(input int unsigned cur, input int unsigned seen);
    return cur > seen;
  endfunction

  // next ray number; zero is reserved for "never tested"
  function automatic int unsigned next_ray_num(input int unsigned cur, input int unsigned top);
    return (cur == top) ? 32'd1 : cur + 32'd1;
  endfunction

  function automatic verdict_e verdict_of(input logic valid, input logic newer);
    if (!valid) return VERD_IDLE;
    return newer ? VERD_PASS : VERD_SKIP;
  endfunction

endpackage

// File: rtl/mbx_ray_counter.sv
module mbx_ray_counter #(
  parameter int RAY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_ray_i,
  output logic [RAY_W-1:0] num_o,
  output logic             wrap_o
);
  localparam logic [RAY_W-1:0] NUM_TOP   = '1;
  localparam logic [RAY_W-1:0] NUM_FIRST = RAY_W'(1);

  logic [RAY_W-1:0] num_q;
  logic [RAY_W-1:0] num_next;

  assign num_next = RAY_W'(mbx_pkg::next_ray_num(32'(num_q), 32'(NUM_TOP)));
  assign wrap_o   = new_ray_i && (num_q == NUM_TOP);
  assign num_o    = num_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         num_q <= NUM_FIRST;
    else if (new_ray_i) num_q <= num_next;
  end

  assert_num_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    num_o != '0);
  assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    new_ray_i && !wrap_o |=> num_o == $past(num_o) + RAY_W'(1));
  assert_hold_without_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !new_ray_i |=> $stable(num_o));
  assert_wrap_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> num_o == NUM_FIRST);

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int PRIM_W = 5,
  parameter int RAY_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [PRIM_W-1:0] wr_addr_i,
  input  logic [RAY_W-1:0]  wr_data_i,
  input  logic [PRIM_W-1:0] rd_addr_i,
  output logic [RAY_W-1:0]  rd_data_o
);
  localparam int ENTRIES = 1 << PRIM_W;

  logic [RAY_W-1:0] mem [ENTRIES];
  logic             hit_fwd;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [RAY_W-1:0] ent_q;
    logic             sel;
    assign sel = wr_en_i && (wr_addr_i == PRIM_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ent_q <= '0;
      else if (clear_i) ent_q <= '0;
      else if (sel)     ent_q <= wr_data_i;
    end
    assign mem[e] = ent_q;

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> ent_q == '0);
  end

  // read-after-write: a store landing on this edge is seen by the reader
  assign hit_fwd   = wr_en_i && (wr_addr_i == rd_addr_i);
  assign rd_data_o = hit_fwd ? wr_data_i : mem[rd_addr_i];

  assert_store_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !clear_i |=> mem[$past(wr_addr_i)] == $past(wr_data_i));

endmodule

// File: rtl/mbx_judge.sv
module mbx_judge #(
  parameter int PRIM_W = 5,
  parameter int RAY_W  = 4,
  parameter int RID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [PRIM_W-1:0] req_prim_i,
  input  logic [RID_W-1:0]  req_ray_i,
  input  logic [RAY_W-1:0]  cur_num_i,
  input  logic              wrap_i,
  input  logic [RAY_W-1:0]  seen_i,
  output logic              wr_en_o,
  output logic [PRIM_W-1:0] wr_addr_o,
  output logic [RAY_W-1:0]  wr_data_o,
  output logic              dec_valid_o,
  output logic              dec_pass_o,
  output logic [PRIM_W-1:0] dec_prim_o,
  output logic [RID_W-1:0]  dec_ray_o,
  output logic [RAY_W-1:0]  dec_num_o,
  output logic              fwd_valid_o
);
  import mbx_pkg::*;

  // stage 1: captured request and its mailbox snapshot
  logic              s1_v;
  logic [PRIM_W-1:0] s1_prim;
  logic [RID_W-1:0]  s1_rid;
  logic [RAY_W-1:0]  s1_num;
  logic [RAY_W-1:0]  s1_seen;
  logic              s1_nowr;
  verdict_e          s1_verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_prim <= '0;
      s1_rid  <= '0;
      s1_num  <= '0;
      s1_seen <= '0;
      s1_nowr <= 1'b0;
    end else begin
      s1_v <= req_valid_i;
      if (req_valid_i) begin
        s1_prim <= req_prim_i;
        s1_rid  <= req_ray_i;
        s1_num  <= cur_num_i;
        s1_seen <= seen_i;
        s1_nowr <= wrap_i;
      end
    end
  end

  assign s1_verdict = verdict_of(s1_v, ray_is_newer(32'(s1_num), 32'(s1_seen)));

  // a request from the wrap cycle belongs to the old numbering: never stored
  assign wr_en_o   = (s1_verdict == VERD_PASS) && !s1_nowr;
  assign wr_addr_o = s1_prim;
  assign wr_data_o = s1_num;

  // stage 2: decision registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_pass_o  <= 1'b0;
      fwd_valid_o <= 1'b0;
      dec_prim_o  <= '0;
      dec_ray_o   <= '0;
      dec_num_o   <= '0;
    end else begin
      dec_valid_o <= (s1_verdict != VERD_IDLE);
      dec_pass_o  <= (s1_verdict == VERD_PASS);
      fwd_valid_o <= (s1_verdict == VERD_PASS);
      dec_prim_o  <= s1_prim;
      dec_ray_o   <= s1_rid;
      dec_num_o   <= s1_num;
    end
  end

  assert_fwd_only_on_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> dec_valid_o && dec_pass_o);
  assert_two_cycle_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> s1_v ##1 dec_valid_o);
  assert_raw_second_skips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o && $past(dec_valid_o) && $past(dec_pass_o)
    && dec_prim_o == $past(dec_prim_o) && dec_num_o == $past(dec_num_o)
    |-> !dec_pass_o);

endmodule

// File: rtl/ray_mailbox_filter.sv
module ray_mailbox_filter #(
  parameter int PRIM_W = 5,
  parameter int RAY_W  = 4,
  parameter int RID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_ray_i,
  input  logic              req_valid_i,
  input  logic [PRIM_W-1:0] req_prim_i,
  input  logic [RID_W-1:0]  req_ray_i,
  output logic              dec_valid_o,
  output logic              dec_pass_o,
  output logic [PRIM_W-1:0] dec_prim_o,
  output logic [RID_W-1:0]  dec_ray_o,
  output logic [RAY_W-1:0]  dec_num_o,
  output logic              fwd_valid_o
);
  // named internal events
  logic [RAY_W-1:0]  cur_num;
  logic              wrap_evt;
  logic [RAY_W-1:0]  seen_num;
  logic              mbox_wr_en;
  logic [PRIM_W-1:0] mbox_wr_addr;
  logic [RAY_W-1:0]  mbox_wr_data;

  mbx_ray_counter #(.RAY_W(RAY_W)) counter_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_ray_i (new_ray_i),
    .num_o     (cur_num),
    .wrap_o    (wrap_evt)
  );

  mbx_store #(.PRIM_W(PRIM_W), .RAY_W(RAY_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (wrap_evt),
    .wr_en_i   (mbox_wr_en),
    .wr_addr_i (mbox_wr_addr),
    .wr_data_i (mbox_wr_data),
    .rd_addr_i (req_prim_i),
    .rd_data_o (seen_num)
  );

  mbx_judge #(.PRIM_W(PRIM_W), .RAY_W(RAY_W), .RID_W(RID_W)) judge_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_prim_i  (req_prim_i),
    .req_ray_i   (req_ray_i),
    .cur_num_i   (cur_num),
    .wrap_i      (wrap_evt),
    .seen_i      (seen_num),
    .wr_en_o     (mbox_wr_en),
    .wr_addr_o   (mbox_wr_addr),
    .wr_data_o   (mbox_wr_data),
    .dec_valid_o (dec_valid_o),
    .dec_pass_o  (dec_pass_o),
    .dec_prim_o  (dec_prim_o),
    .dec_ray_o   (dec_ray_o),
    .dec_num_o   (dec_num_o),
    .fwd_valid_o (fwd_valid_o)
  );

  assert_decision_numbered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_o |-> dec_num_o != '0);
  assert_store_never_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_wr_en |-> mbox_wr_data != '0);

endmodule

// File: tb/ray_mailbox_filter_tb_top.sv
module ray_mailbox_filter_tb_top;
  localparam int PRIM_W = 5;
  localparam int RAY_W  = 4;
  localparam int RID_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              new_ray_i = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [PRIM_W-1:0] req_prim_i = '0;
  logic [RID_W-1:0]  req_ray_i = '0;
  logic              dec_valid_o, dec_pass_o, fwd_valid_o;
  logic [PRIM_W-1:0] dec_prim_o;
  logic [RID_W-1:0]  dec_ray_o;
  logic [RAY_W-1:0]  dec_num_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ray_mailbox_filter #(.PRIM_W(PRIM_W), .RAY_W(RAY_W), .RID_W(RID_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .new_ray_i(new_ray_i), .req_valid_i(req_valid_i),
    .req_prim_i(req_prim_i), .req_ray_i(req_ray_i), .dec_valid_o(dec_valid_o),
    .dec_pass_o(dec_pass_o), .dec_prim_o(dec_prim_o), .dec_ray_o(dec_ray_o),
    .dec_num_o(dec_num_o), .fwd_valid_o(fwd_valid_o)
  );

  typedef struct packed {
    logic        nr;
    logic        v;
    logic [4:0]  prim;
    logic [7:0]  rid;
    logic        ep;
    logic [3:0]  en;
    logic [3:0]  rq;
  } vec_t;

  function automatic string rq_name(input int code);
    case (code)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  // nr, v, prim, rid, expected pass, expected number, requirement
  localparam vec_t TBL [15] = '{
    '{1'b0, 1'b1, 5'd3, 8'd10, 1'b1, 4'd1, 4'd3},
    '{1'b0, 1'b1, 5'd3, 8'd10, 1'b0, 4'd1, 4'd6},
    '{1'b0, 1'b1, 5'd5, 8'd10, 1'b1, 4'd1, 4'd9},
    '{1'b0, 1'b0, 5'd0, 8'd0,  1'b0, 4'd0, 4'd5},
    '{1'b0, 1'b1, 5'd3, 8'd10, 1'b0, 4'd1, 4'd4},
    '{1'b1, 1'b1, 5'd5, 8'd10, 1'b0, 4'd1, 4'd2},
    '{1'b0, 1'b1, 5'd3, 8'd11, 1'b1, 4'd2, 4'd10},
    '{1'b0, 1'b1, 5'd3, 8'd11, 1'b0, 4'd2, 4'd6},
    '{1'b0, 1'b1, 5'd5, 8'd11, 1'b1, 4'd2, 4'd10},
    '{1'b0, 1'b1, 5'd5, 8'd11, 1'b0, 4'd2, 4'd4},
    '{1'b1, 1'b0, 5'd0, 8'd0,  1'b0, 4'd0, 4'd2},
    '{1'b0, 1'b1, 5'd9, 8'd12, 1'b1, 4'd3, 4'd2},
    '{1'b0, 1'b1, 5'd9, 8'd12, 1'b0, 4'd3, 4'd6},
    '{1'b0, 1'b0, 5'd0, 8'd0,  1'b0, 4'd0, 4'd5},
    '{1'b0, 1'b0, 5'd0, 8'd0,  1'b0, 4'd0, 4'd5}
  };

  // expectations in flight: slot 1 is due at the current negedge
  vec_t pend [2];

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check_due();
    vec_t e;
    e = pend[1];
    checks++;
    if (!e.v) begin
      if (dec_valid_o !== 1'b0 || fwd_valid_o !== 1'b0) begin
        errors++;
        $display("FAIL %s idle slot: valid=%b fwd=%b expected 0 0",
                 rq_name(int'(e.rq)), dec_valid_o, fwd_valid_o);
      end
    end else if (dec_valid_o !== 1'b1 || dec_pass_o !== e.ep || fwd_valid_o !== e.ep ||
                 dec_num_o !== e.en || dec_prim_o !== e.prim || dec_ray_o !== e.rid) begin
      errors++;
      $display("FAIL %s v/pass/fwd/num/prim/ray = %b/%b/%b/%0d/%0d/%0d expected 1/%b/%b/%0d/%0d/%0d",
               rq_name(int'(e.rq)), dec_valid_o, dec_pass_o, fwd_valid_o, dec_num_o,
               dec_prim_o, dec_ray_o, e.ep, e.ep, e.en, e.prim, e.rid);
    end
  endtask

  task automatic step(input vec_t x);
    @(negedge clk);
    check_due();
    pend[1] = pend[0];
    pend[0] = x;
    new_ray_i   = x.nr;
    req_valid_i = x.v;
    req_prim_i  = x.prim;
    req_ray_i   = x.rid;
  endtask

  function automatic vec_t mk(input logic nr, input logic v, input int prim, input int rid,
                              input logic ep, input int en, input int rq);
    vec_t r;
    r.nr = nr; r.v = v; r.prim = 5'(prim); r.rid = 8'(rid);
    r.ep = ep; r.en = 4'(en); r.rq = 4'(rq);
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    new_ray_i = 1'b0; req_valid_i = 1'b0; req_prim_i = '0; req_ray_i = '0;
    pend[0] = '0; pend[1] = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing signalled right after reset
    checks++;
    if (dec_valid_o !== 1'b0 || fwd_valid_o !== 1'b0 || dec_pass_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset valid/pass/fwd=%b/%b/%b expected 0/0/0",
               dec_valid_o, dec_pass_o, fwd_valid_o);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    pend[0] = '0; pend[1] = '0;
    do_reset();

    // vector table: first number is 1 (R1), reuse and ray advance
    for (int i = 0; i < 15; i++) step(TBL[i]);

    // mid-run reset: a primitive tested before passes again with number 1 (R1, R3)
    do_reset();
    step(mk(0, 1, 3, 40, 1, 1, 3));
    step(mk(0, 1, 3, 40, 0, 1, 6));

    // R7/R8: walk the number to its top and wrap
    step(mk(0, 1, 7, 50, 1, 1, 3));
    for (int k = 0; k < 13; k++) step(mk(1, 0, 0, 0, 0, 0, 2));
    step(mk(1, 0, 0, 0, 0, 0, 2));                // number now 15
    step(mk(0, 1, 7, 51, 1, 15, 10));             // newer than 1
    step(mk(0, 1, 7, 51, 0, 15, 6));              // back-to-back duplicate
    step(mk(0, 1, 8, 51, 1, 15, 9));              // store lands on the clear edge
    step(mk(1, 1, 20, 51, 1, 15, 8));             // wrap cycle: old number, no store
    step(mk(0, 1, 20, 52, 1, 1, 8));              // R8: no trace left
    step(mk(0, 1, 8, 52, 1, 1, 7));               // R7: clear beat the store
    step(mk(0, 1, 7, 52, 1, 1, 7));               // R7: cleared entry
    step(mk(0, 1, 7, 52, 0, 1, 6));
    step(mk(0, 1, 20, 52, 0, 1, 4));              // stored under number 1 now
    step(mk(0, 0, 0, 0, 0, 0, 5));
    step(mk(0, 0, 0, 0, 0, 0, 5));
    step(mk(0, 0, 0, 0, 0, 0, 5));

    finish_run();
  end

endmodule